// File: doc/BRIEF.md
# Dual-Mode Watchdog / Countdown Timer

This block is a single 8-bit down-counter that serves either as a watchdog or as a periodic countdown timer. Only one of the two runs at a time. It is clocked by the 32.768 kHz base clock. A prescaler derives one of four tick rates from that clock, and each selected tick moves the count one step toward zero. Software drives the block through two write-only registers: a control register and a value register.

In watchdog mode, the count reaching zero is a timeout. It either raises a sticky interrupt flag or emits a reset pulse of fixed length, as the action bit selects. Software keeps the watchdog from expiring by writing the value register again before the count runs out. In countdown mode, the end of the count always raises the interrupt flag and the counter reloads from the last written value, so it fires periodically. If both enables are set, the watchdog runs and the countdown enable has no effect.

The tick periods are parameters given in base-clock cycles. The defaults are 8, 512, 32768 and 1966080, which give 4096 Hz, 64 Hz, 1 Hz and 1/60 Hz.

Top module: `wdt_cd_timer`

## Requirements
- R1: After reset, irqFlag and rstPulse are 0, count is 0 and the timer is idle.
- R2: A write with wrAddr=1 loads wrData into count and into the reload store. The new value is visible on count in the cycle after the write edge. The write also restarts the prescaler, and it takes priority over a tick in the same cycle.
- R3: The control write field wrData[1:0] selects the tick period: 0 selects DIV0, 1 selects DIV1, 2 selects DIV2 and 3 selects DIV3 base cycles. When a value N is loaded at edge E, count is N-k after edge E+k*DIVsel.
- R4: While count is 0, it stays 0 and no timeout occurs until a new value is written.
- R5: Watchdog mode is control bit 7. With action bit 5 at 0, the count stepping from 1 to 0 sets irqFlag after edge E+N*DIVsel, and count then stays at 0.
- R6: In watchdog mode with action bit 5 at 1, a timeout drives rstPulse high for exactly PULSE_LEN cycles, starting after the timeout edge, and leaves irqFlag unchanged.
- R7: In watchdog mode, writing the value register before the count expires restarts the count, and no timeout occurs.
- R8: Countdown mode is control bit 6 with bit 7 clear. At the end of the count it sets irqFlag, never drives rstPulse whatever bit 5 holds, and reloads count with the stored value.
- R9: With control bits 7 and 6 both set, the block behaves as a watchdog, including the reset-pulse action.
- R10: irqFlag stays set until a control write with bit 4 set clears it, and it never clears otherwise. Bit 4 is not stored.
- R11: With bits 7 and 6 both clear, the timer is idle and count holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz base clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | 0 selects the control register, 1 selects the value register |
| wrData | input | 8 | Write data |
| irqFlag | output | 1 | Sticky interrupt flag |
| rstPulse | output | 1 | Watchdog reset pulse |
| count | output | CNT_W | Current counter value |

## Verification
A table runs every tick source under the watchdog interrupt action, the watchdog reset action, countdown mode with the action bit both clear and set, and both enables set together. For each case the bench checks that nothing fires one cycle before N*DIV and that the right output fires exactly at it, which exposes a wrong divisor, an off-by-one prescaler or a wrong mode priority. The count left after the timeout separates the reload of countdown mode from the stop at zero of watchdog mode. Directed cases cover:
- repeated kicks that must hold off the timeout;
- a zero load that must never fire;
- idle hold;
- intermediate counts;
- the exact reset-pulse width;
- a sticky flag that must survive until it is cleared explicitly.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_WATCH = 2'd1,
    MODE_COUNT = 2'd2
  } timerMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // load count from write data
    logic dec;     // step the count on a tick
    logic reload;  // on this step, refill from reload store
    logic clrPre;  // restart the prescaler
  } dpStrobe_t;

  localparam int CTRL_WD_BIT  = 7;
  localparam int CTRL_CD_BIT  = 6;
  localparam int CTRL_ACT_BIT = 5;
  localparam int CTRL_CLR_BIT = 4;
  localparam int SRC_W        = 2;
  localparam int NUM_SRC      = 4;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV0 = 8,
  parameter int DIV1 = 512,
  parameter int DIV2 = 32768,
  parameter int DIV3 = 1966080
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clrPre,
  input  logic [1:0] srcSel,
  output logic       tick
);
  localparam int MAX_A = (DIV0 > DIV1) ? DIV0 : DIV1;
  localparam int MAX_B = (DIV2 > DIV3) ? DIV2 : DIV3;
  localparam int MAX_DIV = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int PRE_W = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;
  localparam int DIVS [wdt_pkg::NUM_SRC] = '{DIV0, DIV1, DIV2, DIV3};

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] limitM1 [wdt_pkg::NUM_SRC];
  logic atLimit;

  for (genvar g = 0; g < wdt_pkg::NUM_SRC; g++) begin : g_lim
    assign limitM1[g] = PRE_W'(DIVS[g] - 1);
  end

  assign atLimit = (preCnt == limitM1[srcSel]);
  assign tick    = atLimit & ~clrPre;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          preCnt <= '0;
    else if (clrPre)    preCnt <= '0;
    else if (atLimit)   preCnt <= '0;
    else                preCnt <= preCnt + 1'b1;
  end
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DIV0 = 8,
  parameter int DIV1 = 512,
  parameter int DIV2 = 32768,
  parameter int DIV3 = 1966080
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [SRC_W-1:0] srcSel,
  input  logic [CNT_W-1:0] loadVal,
  output logic             tick,
  output logic             atOne,
  output logic             isZero,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] reloadQ;

  wdt_prescaler #(
    .DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)
  ) pre_i (
    .clk(clk),
    .rstN(rstN),
    .clrPre(strobe.clrPre),
    .srcSel(srcSel),
    .tick(tick)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      reloadQ <= '0;
    end else if (strobe.load) begin
      cntQ    <= loadVal;
      reloadQ <= loadVal;
    end else if (strobe.dec) begin
      if (strobe.reload) cntQ <= reloadQ;
      else               cntQ <= cntQ - 1'b1;
    end
  end

  assign atOne  = (cntQ == CNT_W'(1));
  assign isZero = (cntQ == '0);
  assign count  = cntQ;
endmodule

// File: rtl/wdt_control.sv
module wdt_control
  import wdt_pkg::*;
#(
  parameter int PULSE_LEN = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrAddr,
  input  logic [7:0]       wrData,
  input  logic             tick,
  input  logic             atOne,
  input  logic             isZero,
  output dpStrobe_t        strobe,
  output logic [SRC_W-1:0] srcSel,
  output logic             irqFlag,
  output logic             rstPulse
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic             wdEnQ, cdEnQ, actQ;
  logic [SRC_W-1:0] selQ;
  logic             irqQ;
  logic [PW-1:0]    pulseCnt;
  timerMode_e       mode;
  logic             ctrlWr, valWr, timeout, wantIrq, wantRst;

  assign ctrlWr = wrEn & ~wrAddr;
  assign valWr  = wrEn & wrAddr;

  always_comb begin
    if (wdEnQ)      mode = MODE_WATCH;
    else if (cdEnQ) mode = MODE_COUNT;
    else            mode = MODE_IDLE;
  end

  always_comb begin
    strobe.load   = valWr;
    strobe.clrPre = wrEn | (mode == MODE_IDLE);
    strobe.dec    = (mode != MODE_IDLE) & tick & ~isZero & ~valWr;
    strobe.reload = atOne & (mode == MODE_COUNT);
  end

  assign timeout = strobe.dec & atOne;
  assign wantIrq = timeout & ((mode == MODE_COUNT) | ~actQ);
  assign wantRst = timeout & (mode == MODE_WATCH) & actQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdEnQ <= 1'b0;
      cdEnQ <= 1'b0;
      actQ  <= 1'b0;
      selQ  <= '0;
    end else if (ctrlWr) begin
      wdEnQ <= wrData[CTRL_WD_BIT];
      cdEnQ <= wrData[CTRL_CD_BIT];
      actQ  <= wrData[CTRL_ACT_BIT];
      selQ  <= wrData[SRC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             irqQ <= 1'b0;
    else if (wantIrq)                      irqQ <= 1'b1;
    else if (ctrlWr & wrData[CTRL_CLR_BIT]) irqQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               pulseCnt <= '0;
    else if (wantRst)        pulseCnt <= PW'(PULSE_LEN);
    else if (pulseCnt != '0) pulseCnt <= pulseCnt - 1'b1;
  end

  assign srcSel   = selQ;
  assign irqFlag  = irqQ;
  assign rstPulse = (pulseCnt != '0);
endmodule

// File: rtl/wdt_cd_timer.sv
module wdt_cd_timer
  import wdt_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int PULSE_LEN = 16,
  parameter int DIV0      = 8,
  parameter int DIV1      = 512,
  parameter int DIV2      = 32768,
  parameter int DIV3      = 1966080
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrAddr,
  input  logic [7:0]       wrData,
  output logic             irqFlag,
  output logic             rstPulse,
  output logic [CNT_W-1:0] count
);
  dpStrobe_t        strobe;
  logic [SRC_W-1:0] srcSel;
  logic             tick, atOne, isZero;

  wdt_control #(.PULSE_LEN(PULSE_LEN)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .tick(tick), .atOne(atOne), .isZero(isZero),
    .strobe(strobe), .srcSel(srcSel),
    .irqFlag(irqFlag), .rstPulse(rstPulse)
  );

  wdt_datapath #(
    .CNT_W(CNT_W), .DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)
  ) dp_i (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .srcSel(srcSel),
    .loadVal(CNT_W'(wrData)),
    .tick(tick), .atOne(atOne), .isZero(isZero),
    .count(count)
  );
endmodule

// File: rtl/wdt_cd_timer_chk.sv
module wdt_cd_timer_chk #(
  parameter int CNT_W     = 8,
  parameter int PULSE_LEN = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             wrAddr,
  input logic [7:0]       wrData,
  input logic             irqFlag,
  input logic             rstPulse,
  input logic [CNT_W-1:0] count
);
  logic [31:0] highRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         highRun <= '0;
    else if (rstPulse) highRun <= highRun + 1;
    else               highRun <= '0;
  end

  // R6
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    highRun <= 32'(PULSE_LEN));

  // R6
  pulse_at_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstPulse) |-> (count == '0));

  // R2
  value_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr) |=> (count == $past(CNT_W'(wrData))));

  // R4
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0 && !(wrEn && wrAddr)) |=> (count == '0));

  // R10
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqFlag) |-> $past(wrEn && !wrAddr && wrData[4]));
endmodule

bind wdt_cd_timer wdt_cd_timer_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .irqFlag(irqFlag), .rstPulse(rstPulse), .count(count)
);

// File: tb/wdt_cd_timer_tb_top.sv
module wdt_cd_timer_tb_top;
  localparam int PLEN = 4;
  localparam int NVEC = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrAddr = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       irqFlag, rstPulse;
  logic [7:0] count;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  wdt_cd_timer #(.CNT_W(8), .PULSE_LEN(PLEN), .DIV0(2), .DIV1(3), .DIV2(5), .DIV3(7)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .irqFlag(irqFlag), .rstPulse(rstPulse), .count(count)
  );

  // {ctrl, value, expIrq, expRst, expCountAfter}
  localparam logic [25:0] VEC [NVEC] = '{
    {8'h80, 8'd3, 1'b1, 1'b0, 8'd0},  // R5 sel0
    {8'h81, 8'd2, 1'b1, 1'b0, 8'd0},  // R5 sel1
    {8'hA2, 8'd2, 1'b0, 1'b1, 8'd0},  // R6 sel2
    {8'h43, 8'd2, 1'b1, 1'b0, 8'd2},  // R8 sel3 reload
    {8'h60, 8'd4, 1'b1, 1'b0, 8'd4},  // R8 action ignored
    {8'hE1, 8'd3, 1'b0, 1'b1, 8'd0},  // R9 both, reset action
    {8'hC0, 8'd1, 1'b1, 1'b0, 8'd0},  // R9 both, irq action
    {8'h83, 8'd5, 1'b1, 1'b0, 8'd0}   // R3 sel3 watchdog
  };

  function automatic int divOf(input logic [1:0] sel);
    case (sel)
      2'd0: return 2;
      2'd1: return 3;
      2'd2: return 5;
      default: return 7;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic quiesce();
    writeReg(1'b1, 8'd0);
    repeat (PLEN + 4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int hiCnt;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq", irqFlag, 0);
    check("R1 rst", rstPulse, 0);
    check("R1 count", count, 0);
    rstN = 1'b1;
    waitEdges(5);
    check("R1 idle count", count, 0);

    // table of vectors
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] c, v;
      int per;
      c = VEC[i][25:18];
      v = VEC[i][17:10];
      per = int'(v) * divOf(c[1:0]);
      quiesce();
      writeReg(1'b0, c | 8'h10);
      writeReg(1'b1, v);
      waitEdges(per - 1);
      check($sformatf("R3 vec%0d early irq", i), irqFlag, 0);
      check($sformatf("R3 vec%0d early rst", i), rstPulse, 0);
      waitEdges(1);
      check($sformatf("R5/R6/R8/R9 vec%0d irq", i), irqFlag, VEC[i][9]);
      check($sformatf("R6/R8/R9 vec%0d rst", i), rstPulse, VEC[i][8]);
      check($sformatf("R8 vec%0d count", i), count, VEC[i][7:0]);
    end

    // R2 load visible
    quiesce();
    writeReg(1'b0, 8'h10);
    writeReg(1'b1, 8'd9);
    check("R2 load", count, 9);
    // R11 idle hold
    waitEdges(30);
    check("R11 hold", count, 9);
    check("R11 irq", irqFlag, 0);

    // R3 intermediate counts, sel2 (5)
    quiesce();
    writeReg(1'b0, 8'h92);
    writeReg(1'b1, 8'd4);
    waitEdges(5);
    check("R3 step1", count, 3);
    waitEdges(5);
    check("R3 step2", count, 2);

    // R4 zero never fires
    quiesce();
    writeReg(1'b0, 8'h90);
    writeReg(1'b1, 8'd0);
    waitEdges(40);
    check("R4 irq", irqFlag, 0);
    check("R4 count", count, 0);

    // R7 kicks
    writeReg(1'b0, 8'h90);
    writeReg(1'b1, 8'd3);
    for (int k = 0; k < 5; k++) begin
      waitEdges(3);
      writeReg(1'b1, 8'd3);
    end
    check("R7 no timeout", irqFlag, 0);
    waitEdges(5);
    check("R7 before expiry", irqFlag, 0);
    waitEdges(1);
    check("R7 expiry", irqFlag, 1);

    // R10 sticky
    waitEdges(10);
    check("R10 sticky", irqFlag, 1);
    writeReg(1'b0, 8'h80);
    check("R10 no clr bit", irqFlag, 1);
    writeReg(1'b0, 8'h90);
    check("R10 cleared", irqFlag, 0);

    // R6 pulse width
    quiesce();
    writeReg(1'b0, 8'hB0);
    writeReg(1'b1, 8'd1);
    waitEdges(2);
    hiCnt = 0;
    for (int k = 0; k < PLEN + 3; k++) begin
      if (rstPulse) hiCnt++;
      waitEdges(1);
    end
    check("R6 pulse width", hiCnt, PLEN);
    check("R6 irq untouched", irqFlag, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule